// File: doc/BRIEF.md
# Indirect Configuration-Read Initiator

This block lets a processor start a configuration read on a multiplexed address/data bus without holding its own register access open. Software stores a target address and a command/byte-enable word in two registers. Once both have been written, the block runs an address phase and a data phase on its own, stores the word the target returns in a data register, and sets a completion flag. Software either polls that flag or enables an interrupt from it. Every register access is acknowledged in the next cycle, so a slow target or one that keeps retrying can never stall the processor past its time-out.

A second, blocking mode is selected by a pin. In this mode a processor read of the data register starts the bus cycle itself, and the acknowledge of that read is withheld until the target has answered. The bus side is deliberately reduced: one address-phase cycle, a data phase that waits for a target acknowledge or retry, and no arbitration or parity.

Top module: `cfg_read_initiator`

## Requirements
- R1: After reset, every bus output, `reg_ack` and `irq` are 0, and the status register (offset 0x044) reads 0.
- R2: When `direct_en`=0, a bus cycle starts only after both the address register (0x150) and the command register (0x158) have been written, in either order. If the second write request is presented in cycle t, `bus_frame` is high in cycle t+2. After only one of the two writes, no cycle starts.
- R3: The address phase lasts exactly one cycle. In it, `bus_frame`=1, `bus_ad_oe`=1, `bus_ad` carries the address register and `bus_cbe` carries the command field (bits 7:4 of register 0x158).
- R4: The data phase follows at once. In it, `bus_irdy`=1, `bus_frame`=0, `bus_ad_oe`=0 and `bus_cbe` carries the byte-enable field (bits 3:0 of 0x158). It is held until the target signals `tgt_ack` or `tgt_retry`.
- R5: `tgt_retry` in the data phase restarts the cycle at the address phase in the next cycle, with the same address and command. Retry takes priority when `tgt_ack` is high in the same cycle.
- R6: On `tgt_ack` without retry, `tgt_data` is stored in the data register (0x154). Status bit 0 (done) is set, and status bit 1 (busy), which is high from the address phase until then, clears.
- R7: Status bits 0 and 2 are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R8: `irq` equals status bit 0 ANDed with bit 0 of the mask register (0x048).
- R9: A write to 0x150 or 0x158 while busy is ignored and sets status bit 2 (error). The running cycle keeps its original address.
- R10: When `direct_en`=0, every register access is acknowledged with `reg_ack`=1 in the cycle after the request, with read data on `reg_rdata`.
- R11: When `direct_en`=1, register writes do not start a cycle. A read of 0x154 starts one with the stored address and command, and its `reg_ack` is withheld. If the read request is in cycle t, the acknowledge comes in cycle t+2+(K+1)(2+W), carrying the target word, where W is the target's wait cycles per data phase and K the number of retries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| direct_en | input | 1 | 1 selects the blocking mode |
| reg_req | input | 1 | One-cycle register access request |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | RAW | Register offset |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid with reg_ack |
| reg_ack | output | 1 | Access acknowledge |
| irq | output | 1 | Completion interrupt |
| bus_ad | output | DW | Address driven in the address phase |
| bus_ad_oe | output | 1 | Enable for bus_ad |
| bus_cbe | output | CBW | Command, then byte enables |
| bus_frame | output | 1 | Address-phase marker |
| bus_irdy | output | 1 | Data-phase marker |
| tgt_ack | input | 1 | Target completes the data phase |
| tgt_retry | input | 1 | Target asks for a restart |
| tgt_data | input | DW | Word returned by the target |

## Verification
A register acknowledge is due one cycle after its request. The address phase is due two cycles after the second of the two programming writes, and the data phase one cycle after that. A target answer shows in the status register one cycle later, and a blocking read is acknowledged 2+(K+1)(2+W) cycles after its request. The bench drives stimulus and samples every output on the falling edge, counting cycles from the request, so each value is read in the exact cycle the register chain makes it due. A target model and a bus monitor in the bench count address phases and compare the byte enables in every data phase. Each retry count is checked against the number of address phases it caused.

// File: rtl/cfgi_pkg.sv
package cfgi_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_t;

  localparam int OFF_ADDR = 'h150;
  localparam int OFF_DATA = 'h154;
  localparam int OFF_CMD  = 'h158;
  localparam int OFF_STAT = 'h044;
  localparam int OFF_MASK = 'h048;

  localparam int ST_DONE = 0;
  localparam int ST_BUSY = 1;
  localparam int ST_ERR  = 2;
endpackage

// File: rtl/cfgi_regs.sv
module cfgi_regs #(
  parameter int DW  = 32,
  parameter int CBW = 4,
  parameter int RAW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           direct_en,
  input  logic           reg_req,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           busy,
  input  logic           cyc_done,
  input  logic [DW-1:0]  cyc_data,
  output logic [DW-1:0]  reg_rdata,
  output logic           reg_ack,
  output logic [DW-1:0]  addr_q,
  output logic [CBW-1:0] cmd_q,
  output logic [CBW-1:0] be_q,
  output logic           start,
  output logic           irq
);
  localparam logic [RAW-1:0] A_ADDR = RAW'(cfgi_pkg::OFF_ADDR);
  localparam logic [RAW-1:0] A_DATA = RAW'(cfgi_pkg::OFF_DATA);
  localparam logic [RAW-1:0] A_CMD  = RAW'(cfgi_pkg::OFF_CMD);
  localparam logic [RAW-1:0] A_STAT = RAW'(cfgi_pkg::OFF_STAT);
  localparam logic [RAW-1:0] A_MASK = RAW'(cfgi_pkg::OFF_MASK);
  localparam int             PADW   = DW - 2 * CBW;

  logic          addr_wr, cmd_wr;
  logic          st_done, st_err, msk;
  logic          dir_pend, dir_run;
  logic [DW-1:0] data_q;
  logic [DW-1:0] rd_mux;
  logic          auto_go, dir_go;

  assign auto_go = !direct_en && addr_wr && cmd_wr && !busy;
  assign dir_go  = dir_pend && !dir_run && !busy;
  assign start   = auto_go || dir_go;
  assign irq     = st_done & msk;

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_ADDR:  rd_mux = addr_q;
      A_DATA:  rd_mux = data_q;
      A_CMD:   rd_mux = {{PADW{1'b0}}, cmd_q, be_q};
      A_STAT:  rd_mux = DW'({st_err, busy, st_done});
      A_MASK:  rd_mux = DW'(msk);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ack   <= 1'b0;
      reg_rdata <= '0;
      addr_q    <= '0;
      cmd_q     <= '0;
      be_q      <= '0;
      data_q    <= '0;
      addr_wr   <= 1'b0;
      cmd_wr    <= 1'b0;
      st_done   <= 1'b0;
      st_err    <= 1'b0;
      msk       <= 1'b0;
      dir_pend  <= 1'b0;
      dir_run   <= 1'b0;
    end else begin
      reg_ack <= 1'b0;
      if (start) begin
        addr_wr <= 1'b0;
        cmd_wr  <= 1'b0;
      end
      if (dir_go) dir_run <= 1'b1;
      if (reg_req) begin
        if (reg_we) begin
          reg_ack <= 1'b1;
          case (reg_addr)
            A_ADDR: begin
              if (busy) st_err <= 1'b1;
              else begin
                addr_q  <= reg_wdata;
                addr_wr <= !direct_en;
              end
            end
            A_CMD: begin
              if (busy) st_err <= 1'b1;
              else begin
                cmd_q  <= reg_wdata[2*CBW-1:CBW];
                be_q   <= reg_wdata[CBW-1:0];
                cmd_wr <= !direct_en;
              end
            end
            A_STAT: begin
              if (reg_wdata[cfgi_pkg::ST_DONE]) st_done <= 1'b0;
              if (reg_wdata[cfgi_pkg::ST_ERR])  st_err  <= 1'b0;
            end
            A_MASK:  msk <= reg_wdata[0];
            default: ;
          endcase
        end else if (direct_en && reg_addr == A_DATA) begin
          dir_pend <= 1'b1;
        end else begin
          reg_ack   <= 1'b1;
          reg_rdata <= rd_mux;
        end
      end
      if (cyc_done) begin
        data_q  <= cyc_data;
        st_done <= 1'b1;
        if (dir_run) begin
          reg_ack   <= 1'b1;
          reg_rdata <= cyc_data;
          dir_pend  <= 1'b0;
          dir_run   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cfgi_phase.sv
module cfgi_phase #(
  parameter int DW  = 32,
  parameter int CBW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [DW-1:0]  addr_q,
  input  logic [CBW-1:0] cmd_q,
  input  logic [CBW-1:0] be_q,
  input  logic           tgt_ack,
  input  logic           tgt_retry,
  output logic [DW-1:0]  bus_ad,
  output logic           bus_ad_oe,
  output logic [CBW-1:0] bus_cbe,
  output logic           bus_frame,
  output logic           bus_irdy,
  output logic           busy,
  output logic           cyc_done
);
  cfgi_pkg::phase_t state;
  logic [DW-1:0]    lat_addr;
  logic [CBW-1:0]   lat_cmd, lat_be;

  assign busy     = (state != cfgi_pkg::PH_IDLE);
  assign cyc_done = (state == cfgi_pkg::PH_DATA) && tgt_ack && !tgt_retry;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= cfgi_pkg::PH_IDLE;
      lat_addr  <= '0;
      lat_cmd   <= '0;
      lat_be    <= '0;
      bus_ad    <= '0;
      bus_ad_oe <= 1'b0;
      bus_cbe   <= '0;
      bus_frame <= 1'b0;
      bus_irdy  <= 1'b0;
    end else begin
      case (state)
        cfgi_pkg::PH_IDLE: begin
          if (start) begin
            lat_addr  <= addr_q;
            lat_cmd   <= cmd_q;
            lat_be    <= be_q;
            state     <= cfgi_pkg::PH_ADDR;
            bus_frame <= 1'b1;
            bus_ad_oe <= 1'b1;
            bus_ad    <= addr_q;
            bus_cbe   <= cmd_q;
          end
        end
        cfgi_pkg::PH_ADDR: begin
          state     <= cfgi_pkg::PH_DATA;
          bus_frame <= 1'b0;
          bus_ad_oe <= 1'b0;
          bus_ad    <= '0;
          bus_cbe   <= lat_be;
          bus_irdy  <= 1'b1;
        end
        cfgi_pkg::PH_DATA: begin
          if (tgt_retry) begin
            state     <= cfgi_pkg::PH_ADDR;
            bus_frame <= 1'b1;
            bus_ad_oe <= 1'b1;
            bus_ad    <= lat_addr;
            bus_cbe   <= lat_cmd;
            bus_irdy  <= 1'b0;
          end else if (tgt_ack) begin
            state    <= cfgi_pkg::PH_IDLE;
            bus_cbe  <= '0;
            bus_irdy <= 1'b0;
          end
        end
        default: state <= cfgi_pkg::PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_read_initiator.sv
module cfg_read_initiator #(
  parameter int DW  = 32,
  parameter int CBW = 4,
  parameter int RAW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           direct_en,
  input  logic           reg_req,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           reg_ack,
  output logic           irq,
  output logic [DW-1:0]  bus_ad,
  output logic           bus_ad_oe,
  output logic [CBW-1:0] bus_cbe,
  output logic           bus_frame,
  output logic           bus_irdy,
  input  logic           tgt_ack,
  input  logic           tgt_retry,
  input  logic [DW-1:0]  tgt_data
);
  logic           busy, start, cyc_done;
  logic [DW-1:0]  addr_q;
  logic [CBW-1:0] cmd_q, be_q;

  cfgi_regs #(.DW(DW), .CBW(CBW), .RAW(RAW)) u_regs (
    .clk(clk), .rst(rst), .direct_en(direct_en),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .cyc_done(cyc_done),
    .cyc_data(tgt_data), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .addr_q(addr_q), .cmd_q(cmd_q), .be_q(be_q), .start(start), .irq(irq)
  );

  cfgi_phase #(.DW(DW), .CBW(CBW)) u_phase (
    .clk(clk), .rst(rst), .start(start), .addr_q(addr_q), .cmd_q(cmd_q),
    .be_q(be_q), .tgt_ack(tgt_ack), .tgt_retry(tgt_retry),
    .bus_ad(bus_ad), .bus_ad_oe(bus_ad_oe), .bus_cbe(bus_cbe),
    .bus_frame(bus_frame), .bus_irdy(bus_irdy), .busy(busy),
    .cyc_done(cyc_done)
  );
endmodule

// File: rtl/cfg_read_initiator_chk.sv
module cfg_read_initiator_chk #(
  parameter int DW  = 32,
  parameter int CBW = 4,
  parameter int RAW = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           direct_en,
  input logic           reg_req,
  input logic           reg_we,
  input logic [RAW-1:0] reg_addr,
  input logic           reg_ack,
  input logic           bus_ad_oe,
  input logic [CBW-1:0] bus_cbe,
  input logic           bus_frame,
  input logic           bus_irdy,
  input logic           tgt_ack,
  input logic           tgt_retry,
  input logic           busy,
  input logic [DW-1:0]  addr_q
);
  localparam logic [RAW-1:0] A_ADDR = RAW'(cfgi_pkg::OFF_ADDR);

  p_addr_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    bus_frame |=> bus_irdy && !bus_frame);

  p_addr_drives_r3: assert property (@(posedge clk) disable iff (rst)
    bus_frame |-> bus_ad_oe && !bus_irdy);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
    bus_irdy && !tgt_ack && !tgt_retry |=> bus_irdy && $stable(bus_cbe));

  p_retry_restart_r5: assert property (@(posedge clk) disable iff (rst)
    bus_irdy && tgt_retry |=> bus_frame);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    bus_irdy && tgt_ack && !tgt_retry |=> !busy && !bus_irdy);

  p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    reg_req && reg_we && reg_addr == A_ADDR && busy |=> addr_q == $past(addr_q));

  p_ack_next_r10: assert property (@(posedge clk) disable iff (rst)
    reg_req && !direct_en |=> reg_ack);
endmodule

bind cfg_read_initiator cfg_read_initiator_chk #(.DW(DW), .CBW(CBW), .RAW(RAW)) u_chk (
  .clk(clk), .rst(rst), .direct_en(direct_en), .reg_req(reg_req),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_ack(reg_ack),
  .bus_ad_oe(bus_ad_oe), .bus_cbe(bus_cbe), .bus_frame(bus_frame),
  .bus_irdy(bus_irdy), .tgt_ack(tgt_ack), .tgt_retry(tgt_retry),
  .busy(busy), .addr_q(addr_q)
);

// File: tb/cfg_read_initiator_bench.sv
`timescale 1ns/1ps
module cfg_read_initiator_bench;
  localparam logic [11:0] A_ADDR = 12'h150, A_DATA = 12'h154, A_CMD = 12'h158,
                          A_STAT = 12'h044, A_MASK = 12'h048;

  logic clk = 0, rst = 1;
  logic direct_en = 0, reg_req = 0, reg_we = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, bus_ad, tgt_data = 0;
  logic reg_ack, irq, bus_ad_oe, bus_frame, bus_irdy;
  logic [3:0] bus_cbe;
  logic tgt_ack = 0, tgt_retry = 0;

  int nchk = 0, nerr = 0;
  int rsp_wait = 0, rsp_retries = 0;
  logic rsp_both = 0;
  logic [31:0] rsp_data = 0;
  logic [3:0] exp_be = 0;
  int frame_cnt = 0, be_bad = 0, oe_bad = 0;
  logic [31:0] last_ad = 0;
  int wcnt = 0, rleft = 0;
  logic in_txn = 0;

  always #2 clk = ~clk;

  cfg_read_initiator u_cfg_read_initiator (
    .clk(clk), .rst(rst), .direct_en(direct_en), .reg_req(reg_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ack(reg_ack), .irq(irq), .bus_ad(bus_ad),
    .bus_ad_oe(bus_ad_oe), .bus_cbe(bus_cbe), .bus_frame(bus_frame),
    .bus_irdy(bus_irdy), .tgt_ack(tgt_ack), .tgt_retry(tgt_retry),
    .tgt_data(tgt_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // target model
  always @(negedge clk) begin
    tgt_ack   <= 1'b0;
    tgt_retry <= 1'b0;
    if (!rst && bus_frame) begin
      wcnt = 0;
      if (!in_txn) begin rleft = rsp_retries; in_txn = 1; end
    end else if (!rst && bus_irdy) begin
      if (wcnt < rsp_wait) wcnt++;
      else if (rleft > 0) begin
        tgt_retry <= 1'b1; tgt_ack <= rsp_both; rleft--; wcnt = 0;
      end else begin
        tgt_ack <= 1'b1; tgt_data <= rsp_data; in_txn = 0;
      end
    end
  end

  // bus monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_frame) begin
        frame_cnt++;
        last_ad = bus_ad;
        if (!bus_ad_oe) oe_bad++;
      end
      if (bus_irdy && bus_cbe !== exp_be) be_bad++;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
    chk(reg_ack === 1'b1, "R10 write ack", 32'(reg_ack), 1);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_req = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_req = 0;
    chk(reg_ack === 1'b1, "R10 read ack", 32'(reg_ack), 1);
    d = reg_rdata;
  endtask

  task automatic poll_done();
    logic [31:0] s;
    for (int n = 0; n < 200; n++) begin
      rd(A_STAT, s);
      if (s[0]) break;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, a_exp, d_exp;
    logic [3:0] c_exp, b_exp;
    int f0, b0, w, k, lat;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(reg_ack === 0 && irq === 0, "R1 ack/irq reset", {reg_ack, irq}, 0);
    chk(bus_frame === 0 && bus_irdy === 0 && bus_ad_oe === 0 && bus_cbe === 0 && bus_ad === 0,
        "R1 bus reset", {bus_frame, bus_irdy, bus_ad_oe, bus_cbe}, 0);
    rd(A_STAT, v);
    chk(v === 0, "R1 status reset", v, 0);

    // indirect sweep
    for (int i = 0; i < 8; i++) begin
      w = i % 3;
      k = (i / 2) % 3;
      rsp_wait = w; rsp_retries = k; rsp_both = i[2];
      a_exp = 32'h8000_0000 | (i << 11) | (i * 4);
      c_exp = 4'hA ^ 4'(i);
      b_exp = ~4'(1 << (i % 4));
      d_exp = 32'hC0DE_0000 + 32'h1111 * i;
      rsp_data = d_exp; exp_be = b_exp;
      wr(A_MASK, 32'(i[1]));
      f0 = frame_cnt; b0 = be_bad;
      if (i[0]) wr(A_CMD, {24'b0, c_exp, b_exp}); else wr(A_ADDR, a_exp);
      repeat (3) @(negedge clk);
      chk(frame_cnt == f0, "R2 no start after one write", frame_cnt, f0);
      if (i[0]) wr(A_ADDR, a_exp); else wr(A_CMD, {24'b0, c_exp, b_exp});
      chk(bus_frame === 0, "R2 frame not yet", 32'(bus_frame), 0);
      @(negedge clk);
      chk(bus_frame === 1 && bus_ad_oe === 1 && bus_ad === a_exp, "R3 address phase", bus_ad, a_exp);
      chk(bus_cbe === c_exp, "R3 command on cbe", 32'(bus_cbe), 32'(c_exp));
      @(negedge clk);
      chk(bus_irdy === 1 && bus_frame === 0 && bus_ad_oe === 0 && bus_cbe === b_exp,
          "R4 data phase", {bus_irdy, bus_frame, bus_ad_oe, bus_cbe}, {3'b100, b_exp});
      poll_done();
      chk(frame_cnt - f0 == k + 1, "R5 address phases per retry", frame_cnt - f0, k + 1);
      chk(be_bad == b0 && oe_bad == 0, "R4 byte enables held", be_bad - b0, 0);
      rd(A_STAT, v);
      chk(v === 32'h1, "R6 done set busy clear", v, 1);
      rd(A_DATA, v);
      chk(v === d_exp, "R6 data captured", v, d_exp);
      chk(irq === i[1], "R8 irq follows mask", 32'(irq), 32'(i[1]));
      wr(A_STAT, 32'h0);
      rd(A_STAT, v);
      chk(v === 32'h1, "R7 write 0 keeps done", v, 1);
      wr(A_STAT, 32'h1);
      rd(A_STAT, v);
      chk(v === 32'h0 && irq === 0, "R7 done cleared", v, 0);
    end

    // write while busy
    rsp_wait = 6; rsp_retries = 1; rsp_both = 0; rsp_data = 32'h1234_5678;
    exp_be = 4'h3; a_exp = 32'h0000_0A00;
    wr(A_ADDR, a_exp);
    wr(A_CMD, {24'b0, 4'hA, 4'h3});
    @(negedge clk);
    wr(A_ADDR, 32'hDEAD_BEEF);
    rd(A_STAT, v);
    chk(v[2] === 1 && v[1] === 1, "R9 error flag while busy", v[2:0], 3'b110);
    poll_done();
    chk(last_ad === a_exp, "R9 restart keeps old address", last_ad, a_exp);
    rd(A_ADDR, v);
    chk(v === a_exp, "R9 address register unchanged", v, a_exp);
    wr(A_STAT, 32'h4);
    rd(A_STAT, v);
    chk(v === 32'h1, "R7 error cleared by write 1", v, 1);
    wr(A_STAT, 32'h1);

    // blocking mode
    direct_en = 1;
    for (int j = 0; j < 3; j++) begin
      w = j; k = j % 2;
      rsp_wait = w; rsp_retries = k; rsp_data = 32'hFACE_0000 + j;
      exp_be = 4'hF; a_exp = 32'h0100_0000 + j * 256;
      f0 = frame_cnt;
      wr(A_ADDR, a_exp);
      wr(A_CMD, {24'b0, 4'hB, 4'hF});
      repeat (3) @(negedge clk);
      chk(frame_cnt == f0, "R11 writes do not start", frame_cnt, f0);
      reg_req = 1; reg_we = 0; reg_addr = A_DATA;
      @(negedge clk);
      reg_req = 0;
      lat = 1;
      chk(reg_ack === 0, "R11 ack withheld", 32'(reg_ack), 0);
      while (reg_ack !== 1 && lat < 100) begin
        @(negedge clk);
        lat++;
      end
      chk(lat == 2 + (k + 1) * (2 + w), "R11 ack latency", lat, 2 + (k + 1) * (2 + w));
      chk(reg_rdata === rsp_data, "R11 returned word", reg_rdata, rsp_data);
      chk(last_ad === a_exp && frame_cnt - f0 == k + 1, "R11 stored address used", last_ad, a_exp);
      @(negedge clk);
      wr(A_STAT, 32'h1);
    end
    direct_en = 0;

    summary();
    $finish;
  end
endmodule